// File: doc/BRIEF.md
# VPW Bus Symbol Receiver

This block decodes a single-wire variable-pulse-width serial bus. It brings the bus level into the clock domain and counts the 1 µs tick-enable pulses between transitions. It then sorts each interval by its level and its length into data bits, frame starts, end-of-data, end-of-frame, break and noise. Data bits are packed into bytes, most significant bit first, and each byte comes out with a one-cycle strobe. Frame events and errors come out as one-cycle pulses. A level output shows an idle bus.

A fast receive mode divides every timing window by four. Two pulse inputs set and clear it. A break that arrives while a frame is being received drops the frame, flags an invalid symbol and takes the block out of fast mode without any outside action.

Top module: `vpw_rx`

## Requirements
- R1: bus_i (1 = active, 0 = passive) passes through a two-flop synchronizer. An interval's length is the number of cycles with tick_i high while that level is held, counting the cycle in which the new level arrives.
- R2: In normal mode a data bit is short for 34–96 ticks and long for 97–163 ticks. Passive short = 1, passive long = 0, active short = 0, active long = 1. Bits that arrive outside a frame are dropped.
- R3: Within a frame, bits are shifted in MSB first. After the eighth bit, byte_o holds the byte and byte_valid_o pulses for one cycle. The first bit of every byte is passive.
- R4: An active interval of 164–239 ticks gives a one-cycle sof_o pulse and starts a new frame with an empty byte.
- R5: Inside a frame, once at least one byte is complete and the bit count is zero, a passive level that reaches 164 ticks pulses eod_o.
- R6: After end-of-data, a passive level that reaches 240 ticks pulses eof_o and closes the frame.
- R7: An active level that reaches 240 ticks pulses break_o. If a frame is open at that point, invalid_o also pulses and the partial frame is dropped without a byte strobe.
- R8: A break during a frame clears fast_mode_o on the following cycle.
- R9: In fast mode every window is a quarter, using integer shift: short 8–23, long 24–40, start 41–59, break and end-of-frame at 60, end-of-data at 41, idle at 75.
- R10: idle_o is high while the bus has been passive for at least 300 ticks (75 in fast mode).
- R11: An active interval shorter than 34 ticks pulses invalid_o and closes any open frame. A passive interval shorter than 34 ticks is ignored.
- R12: If a passive level reaches 164 ticks inside a frame while a byte is only partly received, invalid_o pulses and the frame is dropped.
- R13: After reset all pulse outputs, idle_o and fast_mode_o are low. fast_set_i sets fast_mode_o and fast_clr_i clears it. When a break clear and fast_set_i happen in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 µs timing enable |
| bus_i | input | 1 | Bus level, 1 = active |
| fast_set_i | input | 1 | Pulse that enters fast mode |
| fast_clr_i | input | 1 | Pulse that leaves fast mode |
| byte_o | output | 8 | Last received byte |
| byte_valid_o | output | 1 | byte_o updated (one cycle) |
| sof_o | output | 1 | Frame start seen |
| eod_o | output | 1 | End-of-data seen |
| eof_o | output | 1 | End-of-frame seen |
| break_o | output | 1 | Break seen |
| invalid_o | output | 1 | Invalid symbol |
| idle_o | output | 1 | Bus idle |
| fast_mode_o | output | 1 | Fast mode active |

## Verification
Some properties are checked on every clock. The interval counter restarts at each transition. Every byte starts with a passive bit. Frame events never overlap. A break inside a frame raises both break and invalid, and drops fast mode on the next cycle. Idle never coincides with a start or a byte strobe. Only the bench scenarios can show the rest: that whole bytes decode correctly under both timing scales and with sparse ticks, and that end-of-data and end-of-frame come at the right points. They also show that noise, glitches, partial bytes and breaks outside a frame lead to the right flags and no others.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;
  localparam int CNT_W = 9;

  typedef enum logic [2:0] {
    CLS_NOISE, CLS_GLITCH, CLS_SHORT, CLS_LONG, CLS_SOF, CLS_PLONG, CLS_BRK
  } sym_cls_e;

  typedef enum logic [1:0] {ST_OUT, ST_FRAME, ST_EOD} rx_state_e;
endpackage

// File: rtl/vpw_edge_timer.sv
module vpw_edge_timer #(
  parameter int CNT_W = vpw_rx_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             bus_i,
  output logic             edge_o,
  output logic             level_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]       sync_q;
  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;

  assign edge_o  = sync_q[1] ^ lvl_q;
  assign level_o = lvl_q;   // on an edge cycle: level of the interval just ended
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], bus_i};
      lvl_q  <= sync_q[1];
      if (edge_o)                         cnt_q <= tick_i ? CNT_W'(1) : '0;
      else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_restart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> cnt_o <= CNT_W'(1));
endmodule

// File: rtl/vpw_sym_class.sv
module vpw_sym_class
  import vpw_rx_pkg::*;
#(
  parameter int CNT_W     = vpw_rx_pkg::CNT_W,
  parameter int SHORT_MIN = 34,
  parameter int LONG_MIN  = 97,
  parameter int SOF_MIN   = 164,
  parameter int BRK_MIN   = 240,
  parameter int IDLE_MIN  = 300
) (
  input  logic             fast_i,
  input  logic             tick_i,
  input  logic             edge_i,
  input  logic             level_i,
  input  logic [CNT_W-1:0] cnt_i,
  output sym_cls_e         cls_o,
  output logic             brk_hit_o,
  output logic             eod_hit_o,
  output logic             eof_hit_o,
  output logic             idle_o
);
  logic [CNT_W-1:0] t_short, t_long, t_sof, t_brk, t_idle;
  logic             step;

  always_comb begin
    t_short = fast_i ? CNT_W'(SHORT_MIN >> 2) : CNT_W'(SHORT_MIN);
    t_long  = fast_i ? CNT_W'(LONG_MIN  >> 2) : CNT_W'(LONG_MIN);
    t_sof   = fast_i ? CNT_W'(SOF_MIN   >> 2) : CNT_W'(SOF_MIN);
    t_brk   = fast_i ? CNT_W'(BRK_MIN   >> 2) : CNT_W'(BRK_MIN);
    t_idle  = fast_i ? CNT_W'(IDLE_MIN  >> 2) : CNT_W'(IDLE_MIN);
  end

  always_comb begin
    if (level_i) begin
      if      (cnt_i < t_short) cls_o = CLS_GLITCH;
      else if (cnt_i < t_long)  cls_o = CLS_SHORT;
      else if (cnt_i < t_sof)   cls_o = CLS_LONG;
      else if (cnt_i < t_brk)   cls_o = CLS_SOF;
      else                      cls_o = CLS_BRK;
    end else begin
      if      (cnt_i < t_short) cls_o = CLS_NOISE;
      else if (cnt_i < t_long)  cls_o = CLS_SHORT;
      else if (cnt_i < t_sof)   cls_o = CLS_LONG;
      else                      cls_o = CLS_PLONG;
    end
  end

  // threshold crossings while the level is still held
  assign step      = tick_i && !edge_i;
  assign brk_hit_o = step &&  level_i && cnt_i == t_brk - 1'b1;
  assign eod_hit_o = step && !level_i && cnt_i == t_sof - 1'b1;
  assign eof_hit_o = step && !level_i && cnt_i == t_brk - 1'b1;
  assign idle_o    = !edge_i && !level_i && cnt_i >= t_idle;
endmodule

// File: rtl/vpw_rx_ctrl.sv
module vpw_rx_ctrl
  import vpw_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       edge_i,
  input  logic       level_i,
  input  sym_cls_e   cls_i,
  input  logic       brk_hit_i,
  input  logic       eod_hit_i,
  input  logic       eof_hit_i,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  output logic       sof_o,
  output logic       eod_o,
  output logic       eof_o,
  output logic       break_o,
  output logic       invalid_o,
  output logic       abort_o
);
  rx_state_e  state_q;
  logic [2:0] bit_cnt_q;
  logic [6:0] shift_q;
  logic       have_byte_q;
  logic       bit_take, bit_val;

  assign bit_take = edge_i && state_q == ST_FRAME && (cls_i == CLS_SHORT || cls_i == CLS_LONG);
  assign bit_val  = ~(level_i ^ (cls_i == CLS_LONG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OUT;   bit_cnt_q <= '0;   shift_q <= '0;   have_byte_q <= 1'b0;
      byte_o <= '0;        byte_valid_o <= 1'b0;  sof_o <= 1'b0;  eod_o <= 1'b0;
      eof_o <= 1'b0;       break_o <= 1'b0;   invalid_o <= 1'b0;  abort_o <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0; sof_o <= 1'b0; eod_o <= 1'b0; eof_o <= 1'b0;
      break_o <= 1'b0;      invalid_o <= 1'b0; abort_o <= 1'b0;
      if (edge_i) begin
        unique case (cls_i)
          CLS_GLITCH: begin
            invalid_o <= 1'b1;
            state_q   <= ST_OUT;
          end
          CLS_SOF: begin
            sof_o       <= 1'b1;
            state_q     <= ST_FRAME;
            bit_cnt_q   <= '0;
            have_byte_q <= 1'b0;
          end
          CLS_SHORT, CLS_LONG: begin
            if (bit_take) begin
              shift_q   <= {shift_q[5:0], bit_val};
              bit_cnt_q <= bit_cnt_q + 1'b1;
              if (bit_cnt_q == 3'd7) begin
                byte_o       <= {shift_q, bit_val};
                byte_valid_o <= 1'b1;
                have_byte_q  <= 1'b1;
              end
            end else if (state_q == ST_EOD) begin
              state_q <= ST_OUT;
            end
          end
          default: if (state_q == ST_EOD) state_q <= ST_OUT;
        endcase
      end else if (brk_hit_i) begin
        break_o <= 1'b1;
        if (state_q == ST_FRAME) begin
          invalid_o <= 1'b1;
          abort_o   <= 1'b1;
          state_q   <= ST_OUT;
        end
      end else if (eod_hit_i && state_q == ST_FRAME) begin
        if (bit_cnt_q == '0 && have_byte_q) begin
          eod_o   <= 1'b1;
          state_q <= ST_EOD;
        end else begin
          invalid_o <= 1'b1;
          state_q   <= ST_OUT;
        end
      end else if (eof_hit_i && state_q == ST_EOD) begin
        eof_o   <= 1'b1;
        state_q <= ST_OUT;
      end
    end
  end

  assert_first_bit_passive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_take && bit_cnt_q == '0) |-> !level_i);
  assert_frame_evt_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sof_o, eod_o, eof_o, byte_valid_o}));
  assert_brk_in_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_hit_i && state_q == ST_FRAME) |=> (break_o && invalid_o && !byte_valid_o));
  assert_eof_needs_eod_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> $past(state_q) == ST_EOD);
endmodule

// File: rtl/vpw_rx.sv
module vpw_rx
  import vpw_rx_pkg::*;
#(
  parameter int CNT_W     = vpw_rx_pkg::CNT_W,
  parameter int SHORT_MIN = 34,
  parameter int LONG_MIN  = 97,
  parameter int SOF_MIN   = 164,
  parameter int BRK_MIN   = 240,
  parameter int IDLE_MIN  = 300
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       bus_i,
  input  logic       fast_set_i,
  input  logic       fast_clr_i,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  output logic       sof_o,
  output logic       eod_o,
  output logic       eof_o,
  output logic       break_o,
  output logic       invalid_o,
  output logic       idle_o,
  output logic       fast_mode_o
);
  logic             edge_w, level_w, brk_hit, eod_hit, eof_hit, abort_w;
  logic [CNT_W-1:0] cnt_w;
  sym_cls_e         cls_w;

  vpw_edge_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .tick_i, .bus_i,
    .edge_o(edge_w), .level_o(level_w), .cnt_o(cnt_w)
  );

  vpw_sym_class #(
    .CNT_W(CNT_W), .SHORT_MIN(SHORT_MIN), .LONG_MIN(LONG_MIN),
    .SOF_MIN(SOF_MIN), .BRK_MIN(BRK_MIN), .IDLE_MIN(IDLE_MIN)
  ) u_class (
    .fast_i(fast_mode_o), .tick_i, .edge_i(edge_w), .level_i(level_w), .cnt_i(cnt_w),
    .cls_o(cls_w), .brk_hit_o(brk_hit), .eod_hit_o(eod_hit), .eof_hit_o(eof_hit),
    .idle_o
  );

  vpw_rx_ctrl u_ctrl (
    .clk_i, .rst_ni, .edge_i(edge_w), .level_i(level_w), .cls_i(cls_w),
    .brk_hit_i(brk_hit), .eod_hit_i(eod_hit), .eof_hit_i(eof_hit),
    .byte_o, .byte_valid_o, .sof_o, .eod_o, .eof_o, .break_o, .invalid_o,
    .abort_o(abort_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      fast_mode_o <= 1'b0;
    else if (abort_w || fast_clr_i)   fast_mode_o <= 1'b0;
    else if (fast_set_i)              fast_mode_o <= 1'b1;
  end

  assert_abort_clears_fast_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_w |=> !fast_mode_o);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (!sof_o && !byte_valid_o));
endmodule

// File: tb/tb_vpw_rx.sv
module tb_vpw_rx;
  localparam int CLK_PERIOD = 10;
  // bit 8 = fast mode, bits 7:0 = byte
  localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h000, 9'h0FF, 9'h13C, 9'h181, 9'h05A};

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, bus = 1'b0, fset = 1'b0, fclr = 1'b0;
  logic [7:0] byte_w;
  logic byte_v, sof, eod, eof, brk, inv, idle, fast;
  logic slow_tick = 1'b0;
  int checks = 0, errors = 0;
  int n_sof = 0, n_eod = 0, n_eof = 0, n_brk = 0, n_inv = 0, n_byte = 0;
  logic [7:0] cap [4];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpw_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_i(bus),
    .fast_set_i(fset), .fast_clr_i(fclr),
    .byte_o(byte_w), .byte_valid_o(byte_v), .sof_o(sof), .eod_o(eod), .eof_o(eof),
    .break_o(brk), .invalid_o(inv), .idle_o(idle), .fast_mode_o(fast)
  );

  always @(negedge clk) begin
    tick <= slow_tick ? ~tick : 1'b1;
    if (rst_n) begin
      if (sof) n_sof++;
      if (eod) n_eod++;
      if (eof) n_eof++;
      if (brk) n_brk++;
      if (inv) n_inv++;
      if (byte_v) begin
        if (n_byte < 4) cap[n_byte] = byte_w;
        n_byte++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int d);
    bus = lvl;
    repeat (d) @(negedge clk);
  endtask

  task automatic clear_counts();
    n_sof = 0; n_eod = 0; n_eof = 0; n_brk = 0; n_inv = 0; n_byte = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input int sh, input int lg);
    for (int k = 0; k < 8; k++) begin
      logic act, v;
      act = k[0];
      v   = b[7-k];
      hold(act, act ? (v ? lg : sh) : (v ? sh : lg));
    end
  endtask

  task automatic pulse(input bit set);
    if (set) fset = 1'b1; else fclr = 1'b1;
    @(negedge clk);
    fset = 1'b0; fclr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check({byte_v, sof, eod, eof, brk, inv, idle, fast} == '0, "R13 reset outputs", 0, 0);
    rst_n = 1'b1;
    hold(1'b0, 320);
    check(idle == 1'b1, "R10 idle after reset", idle, 1);

    // table-driven single-byte frames, R2 R3 R4 R5 R6 R9
    for (int i = 0; i < 6; i++) begin
      bit f;
      int sh, lg;
      f  = VEC[i][8];
      sh = f ? 16 : 64;
      lg = f ? 32 : 128;
      if (f) pulse(1'b1);
      clear_counts();
      hold(1'b1, f ? 50 : 200);
      send_byte(VEC[i][7:0], sh, lg);
      hold(1'b0, f ? 90 : 320);
      check(n_byte == 1 && cap[0] == VEC[i][7:0], f ? "R9 fast byte" : "R2 byte value",
            int'(cap[0]), int'(VEC[i][7:0]));
      check(n_sof == 1, "R4 sof count", n_sof, 1);
      check(n_eod == 1 && n_eof == 1, "R5 R6 eod/eof", n_eod * 10 + n_eof, 11);
      check(n_inv == 0 && idle, "R10 clean idle after frame", n_inv, 0);
      if (f) pulse(1'b0);
    end
    check(fast == 1'b0, "R13 fast cleared by pulse", fast, 0);

    // R3 two-byte frame MSB first
    clear_counts();
    hold(1'b1, 200);
    send_byte(8'h12, 64, 128);
    send_byte(8'h34, 64, 128);
    hold(1'b0, 320);
    check(n_byte == 2 && cap[0] == 8'h12 && cap[1] == 8'h34, "R3 two bytes",
          int'({cap[0], cap[1]}), 16'h1234);

    // R1 sparse ticks, durations doubled in cycles
    slow_tick = 1'b1;
    clear_counts();
    hold(1'b1, 400);
    send_byte(8'hC3, 128, 256);
    hold(1'b0, 640);
    check(n_byte == 1 && cap[0] == 8'hC3 && n_eof == 1, "R1 tick counting", int'(cap[0]), 8'hC3);
    slow_tick = 1'b0;

    // R7 R8 break inside a fast frame
    pulse(1'b1);
    check(fast == 1'b1, "R13 fast set", fast, 1);
    clear_counts();
    hold(1'b1, 50);
    hold(1'b0, 16);
    hold(1'b1, 70);
    hold(1'b0, 100);
    check(n_brk == 1 && n_inv == 1 && n_byte == 0, "R7 break in frame", n_brk + n_inv, 2);
    check(fast == 1'b0, "R8 break drops fast mode", fast, 0);

    // R7 break outside a frame: no invalid
    clear_counts();
    hold(1'b1, 260);
    hold(1'b0, 320);
    check(n_brk == 1 && n_inv == 0 && n_sof == 0, "R7 break out of frame", n_inv, 0);

    // R11 active glitch
    clear_counts();
    hold(1'b1, 20);
    hold(1'b0, 320);
    check(n_inv == 1, "R11 active glitch invalid", n_inv, 1);

    // R11 passive noise ignored, out-of-frame bits dropped (R2)
    clear_counts();
    hold(1'b1, 64);
    hold(1'b0, 20);
    hold(1'b1, 64);
    hold(1'b0, 320);
    check(n_inv == 0 && n_sof == 0 && n_byte == 0, "R11 passive noise ignored", n_inv, 0);

    // R12 passive long mid-byte
    clear_counts();
    hold(1'b1, 200);
    hold(1'b0, 64);
    hold(1'b1, 64);
    hold(1'b0, 320);
    check(n_inv == 1 && n_byte == 0 && n_eod == 0, "R12 partial byte dropped", n_inv, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule